// File: doc/BRIEF.md
# Byte ALU Execute Stage for a 14-bit Instruction Word

This block is the data-processing execute stage of a small accumulator machine. The machine has one working register W, a file of byte registers, and C (carry), DC (nibble carry) and Z (zero) status flags. The fetch and register-file logic presents one 14-bit instruction word per cycle, with `in_valid` high. Alongside it come the current W, the byte read from the addressed register and the current flags.

The stage has two register levels. The first level latches the decoded operation and its operands. The second level registers the result and the write strobes. It also registers the new flag values and a mask of the flags that the instruction changes. The surrounding core uses `wr_w` or `wr_f` (with `f_addr`) to commit the result. It copies `c_out`, `dc_out` and `z_out` back into its status register.

The result, the write strobe and the flags depend on the instruction group:
- Byte operations on a register send their result to W or back to the register, as the destination bit selects.
- Single-bit set and clear operations always write the register.
- Literal operations always write W.

Words that do not process data, such as jumps, calls, returns, bit tests and no-operation, pass through without any write and without changing any flag.

The pipeline has no states beyond its two valid bits. Each cycle, the first level either holds an instruction or is empty, and the second level follows it one cycle later.

Top module: `alu14_exec`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `wr_w`, `wr_f` and `flag_upd` are all 0.
- R2: Take an instruction sampled with `in_valid` high at a rising edge. Its outputs are presented with `out_valid` high after the next rising edge. Instructions may be issued every cycle and they leave in issue order.
- R3: For words with bits [13:12] = 00 that write a result, bit 7 = 0 raises `wr_w` and bit 7 = 1 raises `wr_f`. `f_addr` equals bits [6:0]. `wr_w` and `wr_f` are never high together, and both are low when `out_valid` is low.
- R4: Two words add:
  - bits [13:8] = 000111 computes f + W;
  - bits [13:9] = 11111 computes literal + W.
  Both give the 8-bit sum, with C = carry out of bit 7 and DC = carry out of bit 3. They update C, DC and Z.
- R5: Two words subtract:
  - bits [13:8] = 000010 computes f − W;
  - bits [13:9] = 11110 computes literal − W.
  Both give the 8-bit difference, with C = 1 when there is no borrow and DC = 1 when the low nibble does not borrow. They update C, DC and Z.
- R6: In group 00, these codes in bits [11:8] update only Z, which is set when the 8-bit result is zero:

  | Code | Result |
  |------|--------|
  | 0101 | f AND W |
  | 0100 | f OR W |
  | 0110 | f XOR W |
  | 1001 | NOT f |
  | 0011 | f − 1 |
  | 1010 | f + 1 |
  | 1000 | f |
- R7: In group 00, code 1101 gives {f[6:0], C} with new C = f[7]. Code 1100 gives {C, f[7:1]} with new C = f[0]. Both update only C.
- R8: In group 00, these codes change no flag:

  | Code | Result |
  |------|--------|
  | 1110 | f with its two nibbles exchanged |
  | 1011 | f − 1 |
  | 1111 | f + 1 |
- R9: Bits [13:8] = 000001 give result 0 and set Z, updating only Z. Bit 7 = 1 targets the register and bit 7 = 0 targets W.
- R10: Bits [13:7] = 0000001 write W into the register without any flag change. Bits [13:7] = 0000000 write nothing.
- R11: For bits [13:12] = 01, bits [11:10] choose the operation:
  - 00 clears bit number [9:7] of f;
  - 01 sets that bit;
  - 1x writes nothing.

  The two writing operations write the register at [6:0] and change no flag.
- R12: For bits [13:12] = 11, the literal is bits [7:0] and the result goes to W. Bits [11:8] choose the operation:
  - 00xx and 01xx load the literal and change no flag;
  - 1000 computes literal OR W and updates only Z;
  - 1001 computes literal AND W and updates only Z;
  - 1010 computes literal XOR W and updates only Z.
- R13: Words with bits [13:12] = 10, and the word group 11 with bits [11:8] = 1011, write nothing and give `flag_upd` = 0.
- R14: `flag_upd` bit 2 is C, bit 1 is DC and bit 0 is Z. A flag whose mask bit is 0 is returned equal to its input value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word and operands are present |
| insn | input | 14 | Instruction word |
| w_in | input | 8 | Current working register |
| f_in | input | 8 | Byte read from the addressed register |
| c_in | input | 1 | Current carry flag |
| dc_in | input | 1 | Current nibble-carry flag |
| z_in | input | 1 | Current zero flag |
| out_valid | output | 1 | Outputs belong to an issued instruction |
| result | output | 8 | Computed byte |
| wr_w | output | 1 | Write result into W |
| wr_f | output | 1 | Write result into the register at f_addr |
| f_addr | output | 7 | Register address of the instruction |
| c_out | output | 1 | New carry flag |
| dc_out | output | 1 | New nibble-carry flag |
| z_out | output | 1 | New zero flag |
| flag_upd | output | 3 | Mask of flags changed, {C, DC, Z} |

## Verification
The bench builds the block with its default parameters: a 14-bit word, 8-bit data and a 7-bit register address. These are the values at which every opcode field lines up with the decode. With these values the directed cases reach every carry and borrow boundary at bit 3 and bit 7, both rotations with each carry input, and every bit number of the set and clear operations. A long stream of back-to-back and gapped random words, with random operands and flags, then exercises the undefined and non-data encodings and the held-flag behaviour.

// File: rtl/alu14_pkg.sv
package alu14_pkg;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_ADD,
        OP_SUB,
        OP_AND,
        OP_IOR,
        OP_XOR,
        OP_NOT,
        OP_DEC,
        OP_INC,
        OP_PASS_A,
        OP_PASS_W,
        OP_ROL,
        OP_ROR,
        OP_SWAP,
        OP_ZERO,
        OP_BCLR
    } alu_op_e;

    typedef enum logic [1:0] {
        DST_NONE,
        DST_W,
        DST_F
    } dst_e;

    // flag mask layout {C, DC, Z}
    localparam logic [2:0] UPD_NONE = 3'b000;
    localparam logic [2:0] UPD_Z    = 3'b001;
    localparam logic [2:0] UPD_C    = 3'b100;
    localparam logic [2:0] UPD_CDZ  = 3'b111;

    typedef struct packed {
        alu_op_e    op;
        logic       bit_set;   // selects set instead of clear for OP_BCLR
        dst_e       dst;
        logic       use_lit;
        logic [2:0] upd;
    } dec_t;

    localparam dec_t DEC_IDLE = '{op: OP_NONE, bit_set: 1'b0, dst: DST_NONE,
                                  use_lit: 1'b0, upd: UPD_NONE};

endpackage

// File: rtl/alu14_decode.sv
module alu14_decode
    import alu14_pkg::*;
#(
    parameter int HI_W = 7
) (
    input  logic [HI_W-1:0] hi,
    output dec_t            dec
);
    localparam int CLS_LSB = HI_W - 2;
    localparam int FN_LSB  = HI_W - 6;

    logic [1:0] cls;
    logic [3:0] fn;
    logic       dbit;
    dst_e       byte_dst;

    assign cls      = hi[CLS_LSB +: 2];
    assign fn       = hi[FN_LSB +: 4];
    assign dbit     = hi[0];
    assign byte_dst = dbit ? DST_F : DST_W;

    always_comb begin
        dec = DEC_IDLE;
        unique case (cls)
            2'b00: begin
                dec.dst = byte_dst;
                unique case (fn)
                    4'b0000: begin
                        if (dbit) begin
                            dec.op  = OP_PASS_W;
                            dec.dst = DST_F;
                        end else begin
                            dec.dst = DST_NONE;
                        end
                    end
                    4'b0001: begin dec.op = OP_ZERO;   dec.upd = UPD_Z;   end
                    4'b0010: begin dec.op = OP_SUB;    dec.upd = UPD_CDZ; end
                    4'b0011: begin dec.op = OP_DEC;    dec.upd = UPD_Z;   end
                    4'b0100: begin dec.op = OP_IOR;    dec.upd = UPD_Z;   end
                    4'b0101: begin dec.op = OP_AND;    dec.upd = UPD_Z;   end
                    4'b0110: begin dec.op = OP_XOR;    dec.upd = UPD_Z;   end
                    4'b0111: begin dec.op = OP_ADD;    dec.upd = UPD_CDZ; end
                    4'b1000: begin dec.op = OP_PASS_A; dec.upd = UPD_Z;   end
                    4'b1001: begin dec.op = OP_NOT;    dec.upd = UPD_Z;   end
                    4'b1010: begin dec.op = OP_INC;    dec.upd = UPD_Z;   end
                    4'b1011: begin dec.op = OP_DEC;    dec.upd = UPD_NONE; end
                    4'b1100: begin dec.op = OP_ROR;    dec.upd = UPD_C;   end
                    4'b1101: begin dec.op = OP_ROL;    dec.upd = UPD_C;   end
                    4'b1110: begin dec.op = OP_SWAP;   dec.upd = UPD_NONE; end
                    default: begin dec.op = OP_INC;    dec.upd = UPD_NONE; end
                endcase
            end
            2'b01: begin
                if (fn[3] == 1'b0) begin
                    dec.op      = OP_BCLR;
                    dec.bit_set = fn[2];
                    dec.dst     = DST_F;
                end
            end
            2'b11: begin
                dec.use_lit = 1'b1;
                dec.dst     = DST_W;
                unique casez (fn)
                    4'b0???: begin dec.op = OP_PASS_A; dec.upd = UPD_NONE; end
                    4'b1000: begin dec.op = OP_IOR;    dec.upd = UPD_Z;   end
                    4'b1001: begin dec.op = OP_AND;    dec.upd = UPD_Z;   end
                    4'b1010: begin dec.op = OP_XOR;    dec.upd = UPD_Z;   end
                    4'b1011: begin dec.op = OP_NONE;   dec.dst = DST_NONE; end
                    4'b110?: begin dec.op = OP_SUB;    dec.upd = UPD_CDZ; end
                    default: begin dec.op = OP_ADD;    dec.upd = UPD_CDZ; end
                endcase
            end
            default: dec = DEC_IDLE;
        endcase
    end

endmodule

// File: rtl/alu14_datapath.sv
module alu14_datapath
    import alu14_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e                     op,
    input  logic                        bit_set,
    input  logic [DATA_W-1:0]           a,
    input  logic [DATA_W-1:0]           w,
    input  logic [$clog2(DATA_W)-1:0]   bitsel,
    input  logic [2:0]                  upd,
    input  logic                        c_in,
    input  logic                        dc_in,
    input  logic                        z_in,
    output logic [DATA_W-1:0]           res,
    output logic                        c_new,
    output logic                        dc_new,
    output logic                        z_new
);
    localparam int NIB = DATA_W / 2;

    logic              sub;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   full_sum;
    logic [NIB:0]      low_sum;
    logic [DATA_W-1:0] bit_mask;
    logic              c_calc;

    assign sub      = (op == OP_SUB);
    assign b_eff    = sub ? ~w : w;
    assign full_sum = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
    assign low_sum  = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, sub};
    assign bit_mask = {{(DATA_W-1){1'b0}}, 1'b1} << bitsel;

    always_comb begin
        c_calc = c_in;
        unique case (op)
            OP_ADD, OP_SUB: begin
                res    = full_sum[DATA_W-1:0];
                c_calc = full_sum[DATA_W];
            end
            OP_AND:    res = a & w;
            OP_IOR:    res = a | w;
            OP_XOR:    res = a ^ w;
            OP_NOT:    res = ~a;
            OP_DEC:    res = a - 1'b1;
            OP_INC:    res = a + 1'b1;
            OP_PASS_A: res = a;
            OP_PASS_W: res = w;
            OP_ROL: begin
                res    = {a[DATA_W-2:0], c_in};
                c_calc = a[DATA_W-1];
            end
            OP_ROR: begin
                res    = {c_in, a[DATA_W-1:1]};
                c_calc = a[0];
            end
            OP_SWAP:   res = {a[NIB-1:0], a[DATA_W-1:NIB]};
            OP_BCLR:   res = bit_set ? (a | bit_mask) : (a & ~bit_mask);
            OP_ZERO:   res = '0;
            default:   res = '0;
        endcase
    end

    assign c_new  = upd[2] ? c_calc : c_in;
    assign dc_new = upd[1] ? low_sum[NIB] : dc_in;
    assign z_new  = upd[0] ? (res == '0) : z_in;

endmodule

// File: rtl/alu14_exec.sv
module alu14_exec
    import alu14_pkg::*;
#(
    parameter int INSN_W = 14,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] insn,
    input  logic [DATA_W-1:0] w_in,
    input  logic [DATA_W-1:0] f_in,
    input  logic              c_in,
    input  logic              dc_in,
    input  logic              z_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              wr_w,
    output logic              wr_f,
    output logic [ADDR_W-1:0] f_addr,
    output logic              c_out,
    output logic              dc_out,
    output logic              z_out,
    output logic [2:0]        flag_upd
);
    localparam int HI_W  = INSN_W - ADDR_W;
    localparam int SEL_W = $clog2(DATA_W);

    // decode of the upper word
    dec_t dec;

    alu14_decode #(.HI_W(HI_W)) u_decode (
        .hi  (insn[INSN_W-1:ADDR_W]),
        .dec (dec)
    );

    // first register level: decoded operation and operands
    logic              v1;
    dec_t              d1;
    logic [DATA_W-1:0] a1;
    logic [DATA_W-1:0] w1;
    logic [SEL_W-1:0]  bs1;
    logic [ADDR_W-1:0] addr1;
    logic              c1, dc1, z1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1    <= 1'b0;
            d1    <= DEC_IDLE;
            a1    <= '0;
            w1    <= '0;
            bs1   <= '0;
            addr1 <= '0;
            c1    <= 1'b0;
            dc1   <= 1'b0;
            z1    <= 1'b0;
        end else begin
            v1 <= in_valid;
            if (in_valid) begin
                d1    <= dec;
                a1    <= dec.use_lit ? insn[DATA_W-1:0] : f_in;
                w1    <= w_in;
                bs1   <= insn[ADDR_W +: SEL_W];
                addr1 <= insn[ADDR_W-1:0];
                c1    <= c_in;
                dc1   <= dc_in;
                z1    <= z_in;
            end
        end
    end

    // execute
    logic [DATA_W-1:0] res_x;
    logic              c_x, dc_x, z_x;

    alu14_datapath #(.DATA_W(DATA_W)) u_datapath (
        .op      (d1.op),
        .bit_set (d1.bit_set),
        .a       (a1),
        .w       (w1),
        .bitsel  (bs1),
        .upd     (d1.upd),
        .c_in    (c1),
        .dc_in   (dc1),
        .z_in    (z1),
        .res     (res_x),
        .c_new   (c_x),
        .dc_new  (dc_x),
        .z_new   (z_x)
    );

    // second register level: committed outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            wr_w      <= 1'b0;
            wr_f      <= 1'b0;
            f_addr    <= '0;
            c_out     <= 1'b0;
            dc_out    <= 1'b0;
            z_out     <= 1'b0;
            flag_upd  <= UPD_NONE;
        end else begin
            out_valid <= v1;
            result    <= res_x;
            wr_w      <= v1 && (d1.dst == DST_W);
            wr_f      <= v1 && (d1.dst == DST_F);
            f_addr    <= addr1;
            c_out     <= c_x;
            dc_out    <= dc_x;
            z_out     <= z_x;
            flag_upd  <= v1 ? d1.upd : UPD_NONE;
        end
    end

endmodule

// File: rtl/alu14_exec_chk.sv
module alu14_exec_chk #(
    parameter int INSN_W = 14,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [INSN_W-1:0] insn,
    input logic [DATA_W-1:0] w_in,
    input logic [DATA_W-1:0] f_in,
    input logic              c_in,
    input logic              dc_in,
    input logic              z_in,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              wr_w,
    input logic              wr_f,
    input logic [ADDR_W-1:0] f_addr,
    input logic              c_out,
    input logic              dc_out,
    input logic              z_out,
    input logic [2:0]        flag_upd
);
    // R1: reset state
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(!rst_n) |-> (!out_valid && !wr_w && !wr_f && flag_upd == 3'b000));

    // R2: issue reaches the output one edge after capture
    a_r2_issue_to_result: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R3: at most one destination, none when idle
    a_r3_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_w && wr_f));
    a_r3_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!wr_w && !wr_f && flag_upd == 3'b000));

    // R6: a Z update reflects the byte produced
    a_r6_z_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_upd[0]) |-> (z_out == (result == '0)));

    // R10: register copy of W
    a_r10_copy_w: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_valid, 2) && $past(insn[INSN_W-1:ADDR_W], 2) == 7'b0000001)
        |-> (wr_f && result == $past(w_in, 2) && flag_upd == 3'b000));

    // R11: bit operations leave all flags alone
    a_r11_bitop_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_valid, 2) && $past(insn[INSN_W-1 -: 2], 2) == 2'b01)
        |-> (flag_upd == 3'b000 && !wr_w));

    // R14: masked-out flags are returned unchanged
    a_r14_c_held: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_valid, 2) && !flag_upd[2]) |-> (c_out == $past(c_in, 2)));
    a_r14_z_held: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_valid, 2) && !flag_upd[0]) |-> (z_out == $past(z_in, 2)));

endmodule

bind alu14_exec alu14_exec_chk #(
    .INSN_W(INSN_W),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/alu14_exec_tb.sv
`timescale 1ns/1ps
module alu14_exec_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [13:0] insn;
    logic [7:0]  w_in, f_in;
    logic        c_in, dc_in, z_in;
    logic        out_valid;
    logic [7:0]  result;
    logic        wr_w, wr_f;
    logic [6:0]  f_addr;
    logic        c_out, dc_out, z_out;
    logic [2:0]  flag_upd;

    always #2.5 clk = ~clk;

    alu14_exec u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
        .w_in(w_in), .f_in(f_in), .c_in(c_in), .dc_in(dc_in), .z_in(z_in),
        .out_valid(out_valid), .result(result), .wr_w(wr_w), .wr_f(wr_f),
        .f_addr(f_addr), .c_out(c_out), .dc_out(dc_out), .z_out(z_out),
        .flag_upd(flag_upd)
    );

    typedef struct {
        logic [7:0] res;
        logic       ww;
        logic       wf;
        logic [6:0] addr;
        logic       c;
        logic       dc;
        logic       z;
        logic [2:0] upd;
        int         cyc;
        string      req;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    int   cyc = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // reference model written from the requirements
    function automatic exp_t model(logic [13:0] i, logic [7:0] w, logic [7:0] f,
                                   logic c, logic dc, logic z);
        exp_t e;
        logic [7:0] k;
        logic       zu;
        k = i[7:0];
        zu = 1'b0;
        e.res = 8'h00; e.ww = 1'b0; e.wf = 1'b0; e.addr = i[6:0];
        e.c = c; e.dc = dc; e.z = z; e.upd = 3'b000; e.cyc = 0; e.req = "R13";
        case (i[13:12])
            2'b00: begin
                case (i[11:8])
                    4'h0: begin e.req = "R10"; if (i[7]) begin e.res = w; e.wf = 1'b1; end end
                    4'h1: begin e.req = "R9"; e.res = 8'h00; zu = 1'b1; end
                    4'h7: begin
                        e.req = "R4"; e.res = f + w;
                        e.c = ({1'b0, f} + {1'b0, w}) > 9'd255;
                        e.dc = ({1'b0, f[3:0]} + {1'b0, w[3:0]}) > 5'd15;
                        e.upd = 3'b110; zu = 1'b1;
                    end
                    4'h2: begin
                        e.req = "R5"; e.res = f - w;
                        e.c = (f >= w); e.dc = (f[3:0] >= w[3:0]);
                        e.upd = 3'b110; zu = 1'b1;
                    end
                    4'h5: begin e.req = "R6"; e.res = f & w; zu = 1'b1; end
                    4'h4: begin e.req = "R6"; e.res = f | w; zu = 1'b1; end
                    4'h6: begin e.req = "R6"; e.res = f ^ w; zu = 1'b1; end
                    4'h9: begin e.req = "R6"; e.res = ~f;    zu = 1'b1; end
                    4'h3: begin e.req = "R6"; e.res = f - 8'd1; zu = 1'b1; end
                    4'hA: begin e.req = "R6"; e.res = f + 8'd1; zu = 1'b1; end
                    4'h8: begin e.req = "R6"; e.res = f;     zu = 1'b1; end
                    4'hD: begin e.req = "R7"; e.res = {f[6:0], c}; e.c = f[7]; e.upd = 3'b100; end
                    4'hC: begin e.req = "R7"; e.res = {c, f[7:1]}; e.c = f[0]; e.upd = 3'b100; end
                    4'hE: begin e.req = "R8"; e.res = {f[3:0], f[7:4]}; end
                    4'hB: begin e.req = "R8"; e.res = f - 8'd1; end
                    default: begin e.req = "R8"; e.res = f + 8'd1; end
                endcase
                if (i[11:8] != 4'h0) begin
                    e.ww = ~i[7];
                    e.wf = i[7];
                end
            end
            2'b01: begin
                e.req = "R11";
                if (i[11:10] == 2'b00) begin
                    e.res = f & ~(8'h01 << i[9:7]); e.wf = 1'b1;
                end else if (i[11:10] == 2'b01) begin
                    e.res = f | (8'h01 << i[9:7]); e.wf = 1'b1;
                end
            end
            2'b11: begin
                e.ww = 1'b1;
                casez (i[11:8])
                    4'b0???: begin e.req = "R12"; e.res = k; end
                    4'b1000: begin e.req = "R12"; e.res = k | w; zu = 1'b1; end
                    4'b1001: begin e.req = "R12"; e.res = k & w; zu = 1'b1; end
                    4'b1010: begin e.req = "R12"; e.res = k ^ w; zu = 1'b1; end
                    4'b1011: begin e.req = "R13"; e.ww = 1'b0; end
                    4'b110?: begin
                        e.req = "R5"; e.res = k - w;
                        e.c = (k >= w); e.dc = (k[3:0] >= w[3:0]);
                        e.upd = 3'b110; zu = 1'b1;
                    end
                    default: begin
                        e.req = "R4"; e.res = k + w;
                        e.c = ({1'b0, k} + {1'b0, w}) > 9'd255;
                        e.dc = ({1'b0, k[3:0]} + {1'b0, w[3:0]}) > 5'd15;
                        e.upd = 3'b110; zu = 1'b1;
                    end
                endcase
            end
            default: e.req = "R13";
        endcase
        if (zu) begin
            e.upd = e.upd | 3'b001;
            e.z = (e.res == 8'h00);
        end
        return e;
    endfunction

    // driver: present one instruction for one cycle, push its expectation
    task automatic issue(input logic [13:0] i, input logic [7:0] w, input logic [7:0] f,
                         input logic c, input logic dc, input logic z);
        exp_t e;
        e = model(i, w, f, c, dc, z);
        e.cyc = cyc + 2;
        q.push_back(e);
        in_valid = 1'b1; insn = i; w_in = w; f_in = f;
        c_in = c; dc_in = dc; z_in = z;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic gap();
        in_valid = 1'b0;
        insn = 14'h3FFF;
        @(negedge clk);
    endtask

    task automatic report(input bit ok, input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // monitor / scoreboard
    initial begin
        exp_t e;
        logic [31:0] av, ev;
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1) begin
                if (out_valid) begin
                    if (q.size() == 0) begin
                        report(1'b0, "R2", "unexpected result", 32'(out_valid), 32'h0);
                    end else begin
                        e = q.pop_front();
                        report(cyc == e.cyc, "R2", "result cycle", 32'(cyc), 32'(e.cyc));
                        av = {8'h00, wr_w, wr_f, ((e.ww | e.wf) ? result : 8'h00),
                              (e.wf ? f_addr : 7'h00), c_out, dc_out, z_out, flag_upd};
                        ev = {8'h00, e.ww, e.wf, ((e.ww | e.wf) ? e.res : 8'h00),
                              (e.wf ? e.addr : 7'h00), e.c, e.dc, e.z, e.upd};
                        report(av == ev, {e.req, " (dest R3, held flags R14)"},
                               "{ww,wf,res,addr,c,dc,z,upd}", av, ev);
                    end
                end else begin
                    report(!wr_w && !wr_f && flag_upd == 3'b000, "R3",
                           "write while idle", {29'h0, wr_w, wr_f, |flag_upd}, 32'h0);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    // stimulus
    initial begin
        logic [31:0] lfsr;
        rst_n = 1'b0; in_valid = 1'b0; insn = '0; w_in = '0; f_in = '0;
        c_in = 1'b0; dc_in = 1'b0; z_in = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state, with a word offered during reset
        in_valid = 1'b1;
        @(negedge clk);
        report(!out_valid && !wr_w && !wr_f && flag_upd == 3'b000, "R1", "reset outputs",
               {28'h0, out_valid, wr_w, wr_f, |flag_upd}, 32'h0);
        in_valid = 1'b0;
        @(negedge clk);
        report(!out_valid && !wr_w && !wr_f, "R1", "reset outputs late",
               {29'h0, out_valid, wr_w, wr_f}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 additions: nibble carry, full carry with zero, bit 7 carry
        issue(14'h0785, 8'h01, 8'h0F, 1'b0, 1'b0, 1'b0);
        issue(14'h0705, 8'h01, 8'hFF, 1'b0, 1'b0, 1'b0);
        issue(14'h0785, 8'h80, 8'h80, 1'b0, 1'b1, 1'b0);
        issue(14'h3E0F, 8'hF1, 8'h00, 1'b0, 1'b0, 1'b0);
        issue(14'h3F00, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0);
        // R5 subtractions: no borrow, borrow, nibble borrow, equal
        issue(14'h0285, 8'h03, 8'h05, 1'b0, 1'b0, 1'b1);
        issue(14'h0205, 8'h05, 8'h03, 1'b1, 1'b1, 1'b1);
        issue(14'h0285, 8'h01, 8'h10, 1'b0, 1'b1, 1'b0);
        issue(14'h0285, 8'h42, 8'h42, 1'b0, 1'b0, 1'b0);
        issue(14'h3C05, 8'h06, 8'h00, 1'b1, 1'b1, 1'b1);
        issue(14'h3D10, 8'h10, 8'h00, 1'b0, 1'b0, 1'b0);
        gap();
        // R6 Z-only operations
        issue(14'h0511, 8'hF0, 8'h0F, 1'b1, 1'b1, 1'b0);
        issue(14'h0491, 8'hF0, 8'h0F, 1'b1, 1'b0, 1'b1);
        issue(14'h0611, 8'h5A, 8'h5A, 1'b0, 1'b1, 1'b0);
        issue(14'h0991, 8'h00, 8'hFF, 1'b1, 1'b1, 1'b0);
        issue(14'h0311, 8'h00, 8'h01, 1'b0, 1'b0, 1'b0);
        issue(14'h0A91, 8'h00, 8'hFF, 1'b1, 1'b0, 1'b0);
        issue(14'h0811, 8'h33, 8'h00, 1'b0, 1'b1, 1'b0);
        // R7 rotations with both carry inputs
        issue(14'h0DA2, 8'h00, 8'h81, 1'b0, 1'b0, 1'b1);
        issue(14'h0D22, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1);
        issue(14'h0CA2, 8'h00, 8'h01, 1'b0, 1'b0, 1'b0);
        issue(14'h0C22, 8'h00, 8'h80, 1'b1, 1'b0, 1'b0);
        // R8 no-flag operations
        issue(14'h0EB3, 8'h00, 8'hA5, 1'b1, 1'b0, 1'b1);
        issue(14'h0BB3, 8'h00, 8'h01, 1'b0, 1'b1, 1'b0);
        issue(14'h0F33, 8'h00, 8'hFF, 1'b1, 1'b1, 1'b0);
        // R9 clears
        issue(14'h01C4, 8'h77, 8'h99, 1'b1, 1'b1, 1'b0);
        issue(14'h0100, 8'h77, 8'h99, 1'b0, 1'b0, 1'b0);
        // R10 register copy and empty words
        issue(14'h00C5, 8'hC3, 8'h00, 1'b1, 1'b0, 1'b1);
        issue(14'h0000, 8'hC3, 8'h12, 1'b0, 1'b1, 1'b0);
        issue(14'h0008, 8'hC3, 8'h12, 1'b1, 1'b1, 1'b1);
        gap();
        gap();
        // R11 bit clear and set on every bit position, and bit tests
        for (int b = 0; b < 8; b++) begin
            issue({4'b0100, 3'(b), 7'h2A}, 8'h00, 8'hFF, 1'b1, 1'b0, 1'b1);
            issue({4'b0101, 3'(b), 7'h15}, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
        end
        issue(14'h1A2A, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1);
        issue(14'h1E2A, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0);
        // R12 literal operations
        issue(14'h3055, 8'hAA, 8'h00, 1'b1, 1'b1, 1'b1);
        issue(14'h3400, 8'hAA, 8'h00, 1'b0, 1'b0, 1'b0);
        issue(14'h3800, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0);
        issue(14'h390F, 8'hF0, 8'h00, 1'b0, 1'b0, 1'b0);
        issue(14'h3AFF, 8'h0F, 8'h00, 1'b1, 1'b0, 1'b1);
        // R13 non-data words
        issue(14'h2123, 8'h11, 8'h22, 1'b1, 1'b1, 1'b1);
        issue(14'h2FFF, 8'h11, 8'h22, 1'b0, 1'b0, 1'b0);
        issue(14'h3B44, 8'h11, 8'h22, 1'b1, 1'b0, 1'b1);

        // random stream, back to back with occasional gaps
        lfsr = 32'h1ACE_B00C;
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (lfsr[3:0] == 4'h0) gap();
            issue(lfsr[13:0], lfsr[21:14], lfsr[29:22] ^ lfsr[7:0],
                  lfsr[30], lfsr[31], lfsr[4]);
        end

        repeat (6) @(negedge clk);
        report(q.size() == 0, "R2", "results outstanding", 32'(q.size()), 32'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule